// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each received frame, whether the frame is kept or dropped. It looks only at the six destination-address bytes at the head of the frame. The bytes arrive one per cycle on a byte stream, and a start marker flags the first byte. One cycle after the sixth byte, the block gives a single-cycle result pulse together with an accept flag.

The host configures the filter through a byte-wide write port. Through this port it loads three things: a 64-bit multicast hash table held as eight bytes, the six-byte station address, and a mode byte.

The filter accepts a frame when any one of these holds:
- promiscuous mode is on;
- the address is broadcast;
- the address equals the station address;
- the address is multicast and either all-multicast mode is on, or hashing is on and the table bit picked by the address hash is set.

The hash is a CRC-32 over the six address bytes. The top six bits of that CRC pick one of the 64 table bits.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `res_valid` and `res_accept` are 0, all table bits are 0, the mode byte is 0 and the station address is all zeros.
- R2: `res_valid` rises in the cycle after the clock edge that takes the sixth address byte, and it lasts exactly one cycle. `res_accept` is 0 whenever `res_valid` is 0.
- R3: When mode bit 0 (promiscuous) is 1, every address is accepted, whatever the other settings are.
- R4: An address of six bytes of 0xFF (broadcast) is always accepted.
- R5: An address whose six bytes equal station register bytes 0..5, in arrival order, is accepted. Station byte k lives at write offset 8+k, and byte 0 is the first byte received.
- R6: When mode bit 1 (all-multicast) is 1, every multicast address is accepted. An address is multicast when bit 0 of its first byte is 1.
- R7: When mode bit 2 (hash enable) is 1, a multicast address is accepted if table bit `idx` is 1. `idx` is bits [31:26] of a CRC. That CRC starts from all ones, uses the polynomial 0x04C11DB7 with MSB-aligned shifting, takes each byte least-significant bit first, and gets no final inversion. Table byte `idx[5:3]` sits at write offset `idx[5:3]`, and `idx[2:0]` picks the bit within that byte.
- R8: An address that is neither broadcast nor equal to the station address, and that does not pass R6 or R7, is rejected. This covers every unicast address other than the station address.
- R9: A byte with the start marker always begins a new address, even in the middle of one. Bytes without the marker, arriving while no address is in progress, are ignored and produce no result.
- R10: The mode byte is at write offset 14, bits [2:0]. A write to offset 15 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| da_valid | input | 1 | Address byte valid |
| da_sof | input | 1 | Marks the first address byte |
| da_byte | input | 8 | Address byte |
| res_valid | output | 1 | Single-cycle decision strobe |
| res_accept | output | 1 | Frame accepted, qualified by `res_valid` |

## Verification
The bench builds the filter with its default parameters: six address bytes, a six-bit hash index over a 64-bit table, and the standard CRC polynomial. At that size, random addresses hit every table byte and every bit position within a few hundred frames. The same small address space lets directed tests force single-bit table hits and misses, station matches, and mid-address restarts.

// File: rtl/rx_dest_filter_pkg.sv
// Package: shared mode layout and the per-byte CRC step of the filter.
// Assumes bytes are fed least-significant bit first into an MSB-aligned CRC.
package rx_dest_filter_pkg;

    // Mode byte layout: bit0 promiscuous, bit1 all-multicast, bit2 hash enable.
    typedef struct packed {
        logic hash_en;
        logic all_mc;
        logic promisc;
    } filt_mode_t;

    // Advance a 32-bit MSB-aligned CRC by one byte, LSB of the byte first.
    function automatic logic [31:0] crc_step_byte(input logic [31:0] crc_in,
                                                  input logic [7:0]  data,
                                                  input logic [31:0] poly);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[31] ^ data[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/rx_dest_filter_regs.sv
// Configuration storage: hash table bytes, station address bytes, mode byte.
// Assumes a single write port; offsets outside the map are silently dropped.
module rx_dest_filter_regs
    import rx_dest_filter_pkg::*;
#(
    parameter int TBL_BYTES  = 8,
    parameter int ADDR_BYTES = 6,
    parameter int AW         = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [7:0]              wdata,
    output logic [TBL_BYTES*8-1:0]  tbl,
    output logic [ADDR_BYTES*8-1:0] station,
    output filt_mode_t              mode
);
    localparam int STA_OFS  = TBL_BYTES;
    localparam int MODE_OFS = TBL_BYTES + ADDR_BYTES;

    logic [7:0] tbl_q [TBL_BYTES];
    logic [7:0] sta_q [ADDR_BYTES];

    for (genvar gi = 0; gi < TBL_BYTES; gi++) begin : g_tbl
        // Hold one byte of the multicast hash table.
        always_ff @(posedge clk) begin
            if (!rst_n)                             tbl_q[gi] <= '0;
            else if (we && waddr == AW'(gi))        tbl_q[gi] <= wdata;
        end
        assign tbl[gi*8 +: 8] = tbl_q[gi];
    end

    for (genvar gs = 0; gs < ADDR_BYTES; gs++) begin : g_sta
        // Hold one byte of the station address.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 sta_q[gs] <= '0;
            else if (we && waddr == AW'(STA_OFS + gs))  sta_q[gs] <= wdata;
        end
        assign station[gs*8 +: 8] = sta_q[gs];
    end

    // Hold the mode byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mode <= '0;
        else if (we && waddr == AW'(MODE_OFS))   mode <= filt_mode_t'(wdata[2:0]);
    end

    // R10: a write away from the mode offset leaves the mode untouched.
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && waddr == AW'(MODE_OFS)) |=> $stable(mode));

endmodule

// File: rtl/rx_dest_filter_seq.sv
// Byte sequencer: tracks the position inside the destination address.
// Assumes a start-marked byte always restarts; unmarked idle bytes are dropped.
module rx_dest_filter_seq #(
    parameter int ADDR_BYTES = 6,
    parameter int CW         = $clog2(ADDR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          da_valid,
    input  logic          da_sof,
    output logic          take,
    output logic          first,
    output logic          last,
    output logic [CW-1:0] pos
);
    logic          active_q;
    logic [CW-1:0] cnt_q;

    assign take  = da_valid && (da_sof || active_q);
    assign first = da_valid && da_sof;
    assign pos   = first ? '0 : cnt_q;
    assign last  = take && (pos == CW'(ADDR_BYTES - 1));

    // Advance the byte position and close the address after its last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (take) begin
            active_q <= !last;
            cnt_q    <= last ? '0 : pos + CW'(1);
        end
    end

    // R9: the position never passes the final address byte.
    p_pos_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(ADDR_BYTES));
    // R9: an idle sequencer sits at position zero.
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> cnt_q == '0);

endmodule

// File: rtl/rx_dest_filter_crc.sv
// Hash generator: running CRC over the address bytes, exposing the hash index.
// Assumes the seed is all ones and no final inversion is applied.
module rx_dest_filter_crc
    import rx_dest_filter_pkg::*;
#(
    parameter int          HASH_BITS = 6,
    parameter logic [31:0] POLY      = 32'h04C1_1DB7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic                 first,
    input  logic [7:0]           data,
    output logic [HASH_BITS-1:0] hash_idx
);
    logic [31:0] crc_q, crc_base, crc_next;

    assign crc_base = first ? 32'hFFFF_FFFF : crc_q;
    assign crc_next = crc_step_byte(crc_base, data, POLY);
    assign hash_idx = crc_next[31 -: HASH_BITS];

    // Keep the running CRC between address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
        else if (take) crc_q <= crc_next;
    end

    // R7: the running CRC only moves when an address byte is taken.
    p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(crc_q));

endmodule

// File: rtl/rx_dest_filter_match.sv
// Decision logic: broadcast, station and multicast checks, registered result.
// Assumes the hash index arrives in the same cycle as the last byte.
module rx_dest_filter_match
    import rx_dest_filter_pkg::*;
#(
    parameter int TBL_BITS   = 64,
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    parameter int CW         = $clog2(ADDR_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    first,
    input  logic                    last,
    input  logic [CW-1:0]           pos,
    input  logic [7:0]              data,
    input  logic [ADDR_BYTES*8-1:0] station,
    input  logic [TBL_BITS-1:0]     tbl,
    input  filt_mode_t              mode,
    input  logic [HASH_BITS-1:0]    hash_idx,
    output logic                    res_valid,
    output logic                    res_accept
);
    logic bc_q, dir_q, mc_q;
    logic bc_n, dir_n, mc_n, hash_hit, accept_n;
    logic [7:0] sta_byte;

    assign sta_byte = station[int'(pos)*8 +: 8];
    assign bc_n     = (first ? 1'b1 : bc_q)  && (data == 8'hFF);
    assign dir_n    = (first ? 1'b1 : dir_q) && (data == sta_byte);
    assign mc_n     = first ? data[0] : mc_q;
    assign hash_hit = tbl[hash_idx];
    assign accept_n = mode.promisc || bc_n || dir_n ||
                      (mc_n && (mode.all_mc || (mode.hash_en && hash_hit)));

    // Carry the per-address match flags across bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_q  <= 1'b0;
            dir_q <= 1'b0;
            mc_q  <= 1'b0;
        end else if (take) begin
            bc_q  <= bc_n;
            dir_q <= dir_n;
            mc_q  <= mc_n;
        end
    end

    // Register the decision one cycle after the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
        end else begin
            res_valid  <= last;
            res_accept <= last && accept_n;
        end
    end

    // R2: the result strobe is a single-cycle pulse.
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R2: accept is qualified by the strobe.
    p_acc_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_accept);
    // R3: promiscuous mode at decision time forces acceptance.
    p_promisc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last && mode.promisc) |=> res_accept);
    // R4: a broadcast address is accepted.
    p_bcast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (last && bc_n) |=> res_accept);

endmodule

// File: rtl/rx_dest_filter.sv
// Top: destination address filter with hash, station and mode configuration.
// Assumes the host writes settings through the byte port; results are pulses.
module rx_dest_filter
    import rx_dest_filter_pkg::*;
#(
    parameter int          ADDR_BYTES = 6,
    parameter int          HASH_BITS  = 6,
    parameter logic [31:0] POLY       = 32'h04C1_1DB7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [3:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    input  logic       da_valid,
    input  logic       da_sof,
    input  logic [7:0] da_byte,
    output logic       res_valid,
    output logic       res_accept
);
    localparam int TBL_BITS  = 2 ** HASH_BITS;
    localparam int TBL_BYTES = TBL_BITS / 8;
    localparam int CW        = $clog2(ADDR_BYTES);

    logic [TBL_BITS-1:0]     tbl;
    logic [ADDR_BYTES*8-1:0] station;
    filt_mode_t              mode;
    logic                    take, first, last;
    logic [CW-1:0]           pos;
    logic [HASH_BITS-1:0]    hash_idx;

    rx_dest_filter_regs #(.TBL_BYTES(TBL_BYTES), .ADDR_BYTES(ADDR_BYTES), .AW(4)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
        .tbl(tbl), .station(station), .mode(mode));

    rx_dest_filter_seq #(.ADDR_BYTES(ADDR_BYTES), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_sof(da_sof),
        .take(take), .first(first), .last(last), .pos(pos));

    rx_dest_filter_crc #(.HASH_BITS(HASH_BITS), .POLY(POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .take(take), .first(first), .data(da_byte),
        .hash_idx(hash_idx));

    rx_dest_filter_match #(.TBL_BITS(TBL_BITS), .ADDR_BYTES(ADDR_BYTES),
                           .HASH_BITS(HASH_BITS), .CW(CW)) u_match (
        .clk(clk), .rst_n(rst_n), .take(take), .first(first), .last(last), .pos(pos),
        .data(da_byte), .station(station), .tbl(tbl), .mode(mode), .hash_idx(hash_idx),
        .res_valid(res_valid), .res_accept(res_accept));

    // R9: a result only follows a clock edge that took an address byte.
    p_res_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(take));

endmodule

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       da_valid = 1'b0;
    logic       da_sof = 1'b0;
    logic [7:0] da_byte = '0;
    logic       res_valid, res_accept;

    int checks = 0;
    int errors = 0;

    logic [63:0] sh_tbl = '0;
    logic [47:0] sh_sta = '0;
    logic [2:0]  sh_mode = '0;

    always #5 clk = ~clk;

    rx_dest_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_sof(da_sof),
        .da_byte(da_byte), .res_valid(res_valid), .res_accept(res_accept));

    function automatic logic [5:0] hidx(input logic [47:0] da);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++)
            for (int i = 0; i < 8; i++) begin
                logic fb = c[31] ^ da[b*8+i];
                c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        return c[31:26];
    endfunction

    function automatic logic exp_acc(input logic [47:0] da);
        logic mc = da[0];
        return sh_mode[0] || (da == 48'hFFFF_FFFF_FFFF) || (da == sh_sta) ||
               (mc && (sh_mode[1] || (sh_mode[2] && sh_tbl[hidx(da)])));
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 8)        sh_tbl[a*8 +: 8] = d;
        else if (a < 14)  sh_sta[(a-8)*8 +: 8] = d;
        else if (a == 14) sh_mode = d[2:0];
    endtask

    task automatic send(input logic [47:0] da, input string req);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_sof = (i == 0); da_byte = da[i*8 +: 8];
        end
        @(negedge clk);
        da_valid = 1'b0; da_sof = 1'b0;
        chk({req, " valid"}, res_valid, 1'b1);
        chk({req, " accept"}, res_accept, exp_acc(da));
        @(negedge clk);
        chk("R2 pulse end", res_valid, 1'b0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [47:0] da;
        logic [5:0]  ix;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid reset", res_valid, 1'b0);
        chk("R1 accept reset", res_accept, 1'b0);
        // R1: zero station accepts the all-zero address; table empty rejects multicast.
        send(48'h0, "R1 zero station");
        send(48'h0000_0000_1101, "R1 empty table");
        // R8: unicast with no match.
        send(48'h5544_3322_1102, "R8 unicast reject");
        // R4: broadcast.
        send(48'hFFFF_FFFF_FFFF, "R4 broadcast");
        // R5: program station and hit it.
        for (int k = 0; k < 6; k++) wr(4'(8 + k), 8'(8'h10 + k * 8'h11));
        send(sh_sta, "R5 station match");
        send(sh_sta ^ 48'h0100_0000_0000, "R8 near station");
        // R10: write to unused offset must not turn on a mode.
        wr(4'd15, 8'hFF);
        send(48'h0000_0000_3301, "R10 unused offset");
        // R7: single table bit hit and miss.
        da = 48'hA1B2_C3D4_E5F1;
        ix = hidx(da);
        wr(4'd14, 8'h04);
        wr({1'b0, ix[5:3]}, 8'(1 << ix[2:0]));
        send(da, "R7 hash hit");
        chk("R7 model hit", exp_acc(da), 1'b1);
        wr({1'b0, ix[5:3]}, 8'(~(1 << ix[2:0])));
        send(da, "R7 hash miss");
        chk("R7 model miss", exp_acc(da), 1'b0);
        // R6: all-multicast.
        wr(4'd14, 8'h02);
        send(da, "R6 all multicast");
        send(da & ~48'h1, "R8 unicast in allmc");
        // R3: promiscuous.
        wr(4'd14, 8'h01);
        send(48'h1234_5678_9ABC, "R3 promiscuous");
        wr(4'd14, 8'h00);
        // R9: restart mid-address.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); da_valid = 1'b1; da_sof = (i == 0); da_byte = 8'hFF;
        end
        send(48'h7766_5544_3322, "R9 restart");
        // R9: unmarked idle bytes yield no result.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); da_valid = 1'b1; da_sof = 1'b0; da_byte = 8'hFF;
            chk("R9 idle ignore", res_valid, 1'b0);
        end
        @(negedge clk); da_valid = 1'b0;
        chk("R9 idle ignore", res_valid, 1'b0);
        // Random mix.
        for (int n = 0; n < 400; n++) begin
            int sel = $urandom_range(0, 9);
            if (n % 25 == 0)
                for (int k = 0; k < 8; k++) wr(4'(k), 8'($urandom));
            if (n % 40 == 0) wr(4'd14, (($urandom_range(0, 7) == 0) ? 8'h01 : 8'h00) |
                                       8'($urandom_range(0, 3) << 1));
            da = {16'($urandom), 32'($urandom)};
            if (sel == 0)      da = sh_sta;
            else if (sel == 1) da = 48'hFFFF_FFFF_FFFF;
            else if (sel < 6)  da[0] = 1'b1;
            else               da[0] = 1'b0;
            send(da, sel < 6 ? "R7 random mc" : "R8 random uc");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule